// File: doc/BRIEF.md
# Dual-Field Bit-Serial Modular Multiplier

This block multiplies two field elements with the modulus reduction folded into every step. With the field select low it works on integers and returns A·B mod P. With the field select high it works on polynomials with one-bit coefficients and no carries, and returns A(x)·B(x) mod F(x). Both kinds of element sit in the same W-bit word, and the same accumulator and step counter serve both fields.

The multiplier operand B is scanned from its top bit down, one bit per clock. On each step the accumulator is doubled, the whole multiplicand A is added when the scanned bit is 1, and a multiple of the modulus is removed in the same cycle. In integer mode the accumulator is kept as a sum vector and a carry vector, two bits wider than the operands. The multiple of P to subtract is chosen from the top five bits of those two vectors. Once the last bit has been scanned, one full add merges the two vectors into plain binary, and two conditional subtractions of P bring the value into range.

The block uses a start/busy/done handshake. A start pulse seen while idle captures the operands, the modulus and the field select. Busy is high while the work runs, and done is high for one cycle when the result register takes the new value.

The state machine has five states. IDLE moves to STEP on start. STEP repeats W times. After the last STEP, a binary-field job goes back to IDLE and an integer job goes to MERGE. MERGE adds the sum and carry vectors. TRIM1 subtracts P once if the value is at least P. TRIM2 makes the same test again, writes the result and returns to IDLE.

Top module: `dfm_mul`

## Requirements
- R1: After reset, busy is 0, done is 0 and result is 0.
- R2: A start pulse seen while idle (busy low) captures op_a, op_b, modulus and field_sel, and busy is 1 from the next cycle until the job ends.
- R3: With field_sel = 0 (integer field), for 2^(W-1) ≤ modulus < 2^W and op_a, op_b < modulus, the result equals op_a·op_b mod modulus and lies in 0..modulus-1.
- R4: With field_sel = 1 (binary field), bit i of every operand is the coefficient of x^i. The modulus input holds the low W coefficients of F(x), and the x^W term is implied. The result equals op_a(x)·op_b(x) mod F(x), computed with coefficient arithmetic mod 2.
- R5: For a start accepted at clock edge e0, done is high after edge e0+W in binary mode and after edge e0+W+3 in integer mode.
- R6: Done is high for exactly one cycle. Busy is low in that cycle, and result keeps its value in every cycle in which done is low.
- R7: A start pulse seen while busy is ignored. The running job keeps its captured operands, mode and timing, and its result is unchanged.
- R8: In integer mode, the value held as sum plus carry stays below 3·modulus on every step. Operands at the top of the range, such as (modulus-1)·(modulus-1), therefore still give correct results.
- R9: A zero operand gives 0, and an operand of 1 returns the other operand, in both modes.
- R10: In binary mode, all-ones polynomials are reduced correctly, including against an all-ones F(x).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication (used only while idle) |
| field_sel | input | 1 | 0 = integer field mod P, 1 = binary polynomial field |
| op_a | input | W | Multiplicand, used at full width on every step |
| op_b | input | W | Multiplier, scanned from its top bit down |
| modulus | input | W | P in integer mode; low coefficients of F(x) in binary mode |
| busy | output | 1 | A job is running |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | W | Last product, held between jobs |

## Verification
The bench builds the block with W = 16. At this width the reference products fit in 64-bit integers, and a carry-less reference product is only 32 bits wide. The moduli tested include 0xFFF1, 0xA001, 0x8003 and 0x8000, which sit at both ends of the allowed range 2^15..2^16-1, so the quotient estimator sees both its largest and its smallest steps. Sixteen-step jobs also make it cheap to run several hundred random operations in each field and to count the exact latency of each one.

// File: rtl/dfm_pkg.sv
package dfm_pkg;

    typedef enum logic {
        FIELD_PRIME = 1'b0,
        FIELD_BIN   = 1'b1
    } field_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_MERGE,
        ST_TRIM1,
        ST_TRIM2
    } state_e;

endpackage

// File: rtl/dfm_csa.sv
// Row of 3:2 compressors. When carry_en is low the row is a plain
// three-way XOR, which is the carry-free polynomial addition.
module dfm_csa #(
    parameter int N = 18
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    input  logic [N-1:0] z,
    input  logic         carry_en,
    output logic [N-1:0] sum,
    output logic [N-1:0] cry
);

    assign cry[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign sum[i] = x[i] ^ y[i] ^ z[i];
        if (i < N - 1) begin : g_carry
            assign cry[i+1] = carry_en & ((x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]));
        end
    end

endmodule

// File: rtl/dfm_qest.sv
// Quotient estimate for the integer step. The top EB bits of the sum
// and carry vectors give a lower bound on the accumulator. The largest
// multiple k*P that does not exceed twice that bound is returned.
module dfm_qest #(
    parameter int W  = 16,
    parameter int AW = W + 2,
    parameter int EB = 5
) (
    input  logic [EB-1:0] s_top,
    input  logic [EB-1:0] c_top,
    input  logic [W-1:0]  modulus,
    output logic [AW-1:0] sub
);

    localparam int QMAX  = 5;
    localparam int MW    = W + 3;
    localparam int SHIFT = W - 2;
    localparam logic [MW-1:0] ROUND = MW'((64'd1 << SHIFT) - 64'd1);

    logic [EB-1:0] est;
    logic [EB-1:0] lower;
    logic [AW-1:0] multiple [1:QMAX];
    logic          fits     [1:QMAX];

    // The truncated sum may be one below the true top field. All ones
    // can only be the wrapped form of zero.
    assign est   = s_top + c_top;
    assign lower = (est == '1) ? '0 : est;

    for (genvar k = 1; k <= QMAX; k++) begin : g_mult
        logic [MW-1:0] mult;
        logic [EB-1:0] thr;
        assign mult        = MW'(k) * MW'(modulus);
        assign thr         = EB'((mult + ROUND) >> SHIFT);
        assign multiple[k] = AW'(mult);
        assign fits[k]     = (thr <= lower);
    end

    always_comb begin
        sub = '0;
        for (int k = 1; k <= QMAX; k++) begin
            if (fits[k]) begin
                sub = multiple[k];
            end
        end
    end

endmodule

// File: rtl/dfm_mul.sv
module dfm_mul #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         field_sel,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] modulus,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);

    import dfm_pkg::*;

    localparam int AW = W + 2;
    localparam int EB = 5;
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    state_e         state, state_n;
    field_e         fld_q;
    logic [W-1:0]   a_q, b_q, p_q;
    logic [CW-1:0]  cnt;
    logic [AW-1:0]  acc_s, acc_c;
    logic [W-1:0]   result_q;
    logic           done_q;

    logic           is_prime;
    logic           last_step;
    logic [AW-1:0]  add_a;
    logic [AW-1:0]  red_term;
    logic [AW-1:0]  sub;
    logic [AW-1:0]  s1, c1, s2, c2raw, c2;
    logic [AW-1:0]  merged;
    logic [AW-1:0]  p_ext;
    logic [AW-1:0]  diff;
    logic           ge_p;

    assign is_prime  = (fld_q == FIELD_PRIME);
    assign last_step = (cnt == '0);

    // ---------------- step datapath ----------------
    assign add_a = b_q[cnt] ? AW'(a_q) : '0;
    assign p_ext = AW'(p_q);

    dfm_qest #(.W(W), .AW(AW), .EB(EB)) u_qest (
        .s_top   (acc_s[AW-1 -: EB]),
        .c_top   (acc_c[AW-1 -: EB]),
        .modulus (p_q),
        .sub     (sub)
    );

    // Integer: subtract q*P as ~(q*P) plus one carried in at bit 0.
    // Binary: clear bit W by XOR with x^W + F(x) when the shift sets it.
    always_comb begin
        if (is_prime) begin
            red_term = ~sub;
        end else if (acc_s[W-1]) begin
            red_term = p_ext | (AW'(1) << W);
        end else begin
            red_term = '0;
        end
    end

    dfm_csa #(.N(AW)) u_csa_add (
        .x        (acc_s << 1),
        .y        (acc_c << 1),
        .z        (add_a),
        .carry_en (is_prime),
        .sum      (s1),
        .cry      (c1)
    );

    dfm_csa #(.N(AW)) u_csa_red (
        .x        (s1),
        .y        (c1),
        .z        (red_term),
        .carry_en (is_prime),
        .sum      (s2),
        .cry      (c2raw)
    );

    assign c2     = {c2raw[AW-1:1], is_prime};
    assign merged = acc_s + acc_c;
    assign ge_p   = (acc_s >= p_ext);
    assign diff   = acc_s - p_ext;

    // ---------------- state register ----------------
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (start) state_n = ST_STEP;
            ST_STEP:  if (last_step) state_n = is_prime ? ST_MERGE : ST_IDLE;
            ST_MERGE: state_n = ST_TRIM1;
            ST_TRIM1: state_n = ST_TRIM2;
            ST_TRIM2: state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // ---------------- data and output registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q    <= FIELD_PRIME;
            a_q      <= '0;
            b_q      <= '0;
            p_q      <= '0;
            cnt      <= '0;
            acc_s    <= '0;
            acc_c    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        fld_q <= field_e'(field_sel);
                        a_q   <= op_a;
                        b_q   <= op_b;
                        p_q   <= modulus;
                        cnt   <= CW'(W - 1);
                        acc_s <= '0;
                        acc_c <= '0;
                    end
                end
                ST_STEP: begin
                    acc_s <= s2;
                    acc_c <= c2;
                    cnt   <= cnt - 1'b1;
                    if (last_step && !is_prime) begin
                        result_q <= W'(s2);
                        done_q   <= 1'b1;
                    end
                end
                ST_MERGE: begin
                    acc_s <= merged;
                    acc_c <= '0;
                end
                ST_TRIM1: begin
                    if (ge_p) acc_s <= diff;
                end
                ST_TRIM2: begin
                    result_q <= W'(ge_p ? diff : acc_s);
                    done_q   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy   = (state != ST_IDLE);
    assign done   = done_q;
    assign result = result_q;

endmodule

// File: rtl/dfm_mul_chk.sv
module dfm_mul_chk #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic [W-1:0]        result,
    input dfm_pkg::state_e     state,
    input dfm_pkg::field_e     fld_q,
    input logic [W+1:0]        acc_s,
    input logic [W+1:0]        acc_c,
    input logic [W-1:0]        p_q
);

    import dfm_pkg::*;

    localparam int AW = W + 2;

    logic [AW-1:0] acc_val;
    logic [AW+1:0] acc_lim;
    logic          prime_work;

    assign acc_val    = acc_s + acc_c;
    assign acc_lim    = (AW+2)'(3) * (AW+2)'(p_q);
    assign prime_work = (fld_q == FIELD_PRIME) && (state == ST_STEP || state == ST_MERGE);

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_prime_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fld_q == FIELD_PRIME) |-> (result < p_q));

    assert_bin_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_q == FIELD_BIN && state == ST_STEP) |-> (acc_c == '0 && acc_s[AW-1:W] == '0));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    assert_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(p_q) && $stable(fld_q)));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prime_work |-> ({2'b00, acc_val} < acc_lim));

endmodule

bind dfm_mul dfm_mul_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result),
    .state  (state),
    .fld_q  (fld_q),
    .acc_s  (acc_s),
    .acc_c  (acc_c),
    .p_q    (p_q)
);

// File: tb/dfm_mul_tb.sv
`timescale 1ns/1ps
module dfm_mul_tb;

    localparam int W = 16;
    localparam int N_VEC = 12;

    // {field_sel, a, b, modulus}
    localparam logic [3*W:0] VEC [N_VEC] = '{
        {1'b0, 16'h1234, 16'h5678, 16'hFFF1},
        {1'b0, 16'hFFF0, 16'hFFF0, 16'hFFF1},
        {1'b0, 16'h0000, 16'hABCD, 16'hFFF1},
        {1'b0, 16'h0001, 16'h9F00, 16'hA001},
        {1'b0, 16'hA000, 16'hA000, 16'hA001},
        {1'b0, 16'h7FFF, 16'h8002, 16'h8003},
        {1'b0, 16'h7FFF, 16'h7FFF, 16'h8000},
        {1'b1, 16'hFFFF, 16'hFFFF, 16'h002D},
        {1'b1, 16'h0001, 16'hBEEF, 16'h002D},
        {1'b1, 16'h8000, 16'h8000, 16'h100B},
        {1'b1, 16'h0000, 16'hFFFF, 16'hFFFF},
        {1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFF}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         field_sel = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] modulus = '0;
    logic         busy;
    logic         done;
    logic [W-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dfm_mul #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .field_sel(field_sel),
        .op_a(op_a), .op_b(op_b), .modulus(modulus),
        .busy(busy), .done(done), .result(result)
    );

    function automatic logic [W-1:0] ref_prime(input logic [W-1:0] a, b, p);
        longint unsigned prod;
        prod = longint'(a) * longint'(b);
        return W'(prod % longint'(p));
    endfunction

    function automatic logic [W-1:0] ref_bin(input logic [W-1:0] a, b, f);
        logic [2*W-1:0] prod;
        logic [2*W-1:0] poly;
        prod = '0;
        for (int i = 0; i < W; i++) begin
            if (b[i]) prod = prod ^ ((2*W)'(a) << i);
        end
        poly = (2*W)'({1'b1, f});
        for (int i = 2*W-1; i >= W; i--) begin
            if (prod[i]) prod = prod ^ (poly << (i - W));
        end
        return W'(prod);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        end
    endtask

    task automatic run_op(input logic fs, input logic [W-1:0] a, b, m, input bit disturb,
                          output logic [W-1:0] res, output int lat,
                          output logic busy_early, output logic busy_at_done,
                          output logic done_after);
        @(negedge clk);
        start = 1'b1; field_sel = fs; op_a = a; op_b = b; modulus = m;
        @(negedge clk);
        start = 1'b0;
        busy_early = busy;
        lat = 0;
        while (!done && lat < 200) begin
            if (disturb && lat == 3) begin
                start = 1'b1; field_sel = ~fs;
                op_a = 16'h1357; op_b = 16'h2468; modulus = 16'hC001;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        res = result;
        busy_at_done = busy;
        @(negedge clk);
        done_after = done;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin : main
        logic [W-1:0] res, exp, a, b, m;
        logic         fs, be, bd, da;
        int           lat;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 result", result, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R3 / R4 / R5 / R9 / R10
        for (int i = 0; i < N_VEC; i++) begin
            {fs, a, b, m} = VEC[i];
            exp = fs ? ref_bin(a, b, m) : ref_prime(a, b, m);
            run_op(fs, a, b, m, 1'b0, res, lat, be, bd, da);
            check(fs ? "R4 table product" : "R3 table product", res, exp);
            check("R5 latency", lat, fs ? W : W + 3);
        end

        // Hand-known corners: R8 (P-1)^2 = 1, R9 identity and zero, R10 all-ones
        run_op(1'b0, 16'hFFF0, 16'hFFF0, 16'hFFF1, 1'b0, res, lat, be, bd, da);
        check("R8 (P-1)^2", res, 16'h0001);
        run_op(1'b0, 16'h0001, 16'h8002, 16'h8003, 1'b0, res, lat, be, bd, da);
        check("R9 prime times one", res, 16'h8002);
        run_op(1'b1, 16'hBEEF, 16'h0001, 16'h002D, 1'b0, res, lat, be, bd, da);
        check("R9 binary times one", res, 16'hBEEF);
        run_op(1'b1, 16'hFFFF, 16'h0000, 16'h002D, 1'b0, res, lat, be, bd, da);
        check("R9 binary times zero", res, 16'h0000);
        run_op(1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, res, lat, be, bd, da);
        check("R10 all-ones", res, ref_bin(16'hFFFF, 16'hFFFF, 16'hFFFF));

        // R2 / R6: handshake shape
        run_op(1'b0, 16'h4321, 16'h1111, 16'hFFF1, 1'b0, res, lat, be, bd, da);
        check("R2 busy after start", be, 1);
        check("R6 busy low with done", bd, 0);
        check("R6 done one cycle", da, 0);
        check("R6 result held", result, res);

        // R7: start while busy is ignored, in both modes
        run_op(1'b0, 16'h9ABC, 16'h7777, 16'hFFF1, 1'b1, res, lat, be, bd, da);
        check("R7 prime result", res, ref_prime(16'h9ABC, 16'h7777, 16'hFFF1));
        check("R7 prime latency", lat, W + 3);
        check("R7 idle after", busy, 0);
        run_op(1'b1, 16'h5A5A, 16'hC3C3, 16'h100B, 1'b1, res, lat, be, bd, da);
        check("R7 binary result", res, ref_bin(16'h5A5A, 16'hC3C3, 16'h100B));
        check("R7 binary latency", lat, W);

        // Random operands, both fields: R3 / R4 / R8
        for (int i = 0; i < 300; i++) begin
            case (i % 4)
                0: m = 16'hFFF1;
                1: m = 16'hA001;
                2: m = 16'h8003;
                default: m = 16'h8000 | W'($urandom);
            endcase
            a = W'($urandom % m);
            b = W'($urandom % m);
            run_op(1'b0, a, b, m, 1'b0, res, lat, be, bd, da);
            check("R3 random prime", res, ref_prime(a, b, m));
        end
        for (int i = 0; i < 300; i++) begin
            m = (i % 2 == 0) ? 16'h002D : W'($urandom);
            a = W'($urandom);
            b = W'($urandom);
            run_op(1'b1, a, b, m, 1'b0, res, lat, be, bd, da);
            check("R4 random binary", res, ref_bin(a, b, m));
        end

        report();
        $finish;
    end

endmodule